// File: doc/BRIEF.md
# Bus-Request DMA Transfer Controller

This block moves a block of words between an I/O device and memory without involving the processor in each word. The processor programs it through a small register port: it chooses a register with a chip select and a two-bit register index, then writes a start address, a word count and a control word. The control word picks the direction, picks burst or cycle-stealing ownership, and carries the start bit.

When the start bit is set, the count is nonzero and the device raises its request, the controller raises bus request. Once the processor answers with bus grant, the controller runs a word cycle. In a word cycle it drives the memory address, pulses the write strobe (device to memory) or the read strobe (memory to device), and acknowledges the device. The address then steps up by one and the count steps down by one. When the last word is done, the controller releases the bus, clears the start bit and raises an interrupt. The interrupt stays high until the processor rewrites the control register.

The memory, the device and the processor's bus-release logic are outside the block. The address and strobe outputs are held at zero, with the drive-enable output low, whenever the controller does not own the bus. The chip-level tri-state pads are controlled by that enable.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: With chip select high, register index 00 selects the address register, 01 the word count and 10 the control word (bit 0 direction, bit 1 burst, bit 2 start). A write on a clock edge loads the selected register. The read-data output shows the selected register combinationally, zero-extended; index 11, or chip select low, reads zero.
- R2: After reset, bus request, interrupt, strobes, acknowledge and drive enable are low, and all registers read zero.
- R3: Bus request rises on the clock edge after a cycle in which start is set, the count is nonzero and the device request is high. A read or write strobe occurs only while bus request and bus grant are both high.
- R4: A word cycle happens in any cycle where the controller holds bus request and sees grant, device request and start with a nonzero count. In that cycle it drives the current address, asserts the device acknowledge, and asserts the write strobe when direction is 0 or the read strobe when direction is 1.
- R5: Each word cycle adds one to the address register and subtracts one from the word count at the closing clock edge.
- R6: In burst mode, bus request stays high from the first word to the last, including cycles where the device request is low; no strobe occurs in those cycles.
- R7: In cycle-stealing mode, bus request is low in the cycle after every word cycle, so an N-word transfer raises bus request N times.
- R8: On the word that brings the count to zero, bus request drops on the next edge, the start bit clears and the interrupt rises. The interrupt stays high until a control-register write clears it.
- R9: Setting start with a word count of zero produces no bus request; the start bit clears and the interrupt rises on the next clock edge.
- R10: A processor write to the address or count register in the same cycle as a word cycle takes precedence over the step of that register. A control write takes precedence over completion for the start bit and the interrupt.
- R11: While bus request and grant are not both high, the drive enable is low and the address and strobe outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cs_i | input | 1 | Register port chip select |
| cfg_rs_i | input | 2 | Register index |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_wdata_i | input | DATA_W | Register write data |
| cfg_rdata_o | output | DATA_W | Register read data |
| dev_req_i | input | 1 | Device transfer request |
| dev_ack_o | output | 1 | Device acknowledge, high during a word cycle |
| bus_req_o | output | 1 | Bus request to the processor |
| bus_gnt_i | input | 1 | Bus grant from the processor |
| bus_drive_o | output | 1 | Enable for the chip-level tri-state drivers |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| irq_o | output | 1 | Completion interrupt |

## Verification
A processor write to the count register can fall in the same clock cycle as a word cycle that would decrement that register. The bench waits for the first write strobe of a ten-word burst and, in that same cycle, writes a count of two. The written value must appear unchanged on readback, while the address still steps. The transfer must then end after exactly two more words at the following addresses, with the scoreboard holding no leftover or extra words.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'b00,
    SEL_CNT  = 2'b01,
    SEL_CTRL = 2'b10,
    SEL_NONE = 2'b11
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OWN  = 1'b1
  } seq_state_e;

  localparam int unsigned CTRL_DIR   = 0;
  localparam int unsigned CTRL_BURST = 1;
  localparam int unsigned CTRL_START = 2;
  localparam int unsigned CTRL_W     = 3;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_i,
  input  logic [1:0]        sel_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              step_i,
  input  logic              finish_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              dir_o,
  output logic              burst_o,
  output logic              start_o,
  output logic              irq_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              dir_q, dir_d, burst_q, burst_d, start_q, start_d;
  logic              irq_q, irq_d;
  logic              addr_wr, cnt_wr, ctrl_wr;
  logic              addr_en, cnt_en, ctrl_en;

  assign addr_wr = cs_i && we_i && (reg_sel_e'(sel_i) == SEL_ADDR);
  assign cnt_wr  = cs_i && we_i && (reg_sel_e'(sel_i) == SEL_CNT);
  assign ctrl_wr = cs_i && we_i && (reg_sel_e'(sel_i) == SEL_CTRL);

  assign addr_en = addr_wr || step_i;
  assign cnt_en  = cnt_wr  || step_i;
  assign ctrl_en = ctrl_wr || finish_i;

  always_comb begin
    addr_d = addr_q;
    if (addr_wr)     addr_d = wdata_i[ADDR_W-1:0];
    else if (step_i) addr_d = addr_q + ADDR_W'(1);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr)      cnt_d = wdata_i[CNT_W-1:0];
    else if (step_i) cnt_d = cnt_q - CNT_W'(1);
  end

  always_comb begin
    dir_d   = dir_q;
    burst_d = burst_q;
    start_d = start_q;
    irq_d   = irq_q;
    if (ctrl_wr) begin
      dir_d   = wdata_i[CTRL_DIR];
      burst_d = wdata_i[CTRL_BURST];
      start_d = wdata_i[CTRL_START];
      irq_d   = 1'b0;
    end else if (finish_i) begin
      start_d = 1'b0;
      irq_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      burst_q <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (ctrl_en) begin
      dir_q   <= dir_d;
      burst_q <= burst_d;
      start_q <= start_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (cs_i) begin
      case (reg_sel_e'(sel_i))
        SEL_ADDR: rdata_o[ADDR_W-1:0] = addr_q;
        SEL_CNT:  rdata_o[CNT_W-1:0]  = cnt_q;
        SEL_CTRL: rdata_o[CTRL_W-1:0] = {start_q, burst_q, dir_q};
        default:  rdata_o = '0;
      endcase
    end
  end

  assign addr_o  = addr_q;
  assign cnt_o   = cnt_q;
  assign dir_o   = dir_q;
  assign burst_o = burst_q;
  assign start_o = start_q;
  assign irq_o   = irq_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !addr_wr |=> addr_q == $past(addr_q) + ADDR_W'(1)); // R5
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_i && !cnt_wr |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R5
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    finish_i && !ctrl_wr |=> irq_q && !start_q); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !ctrl_wr |=> irq_q); // R8
  AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(wdata_i[CNT_W-1:0])); // R10

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             burst_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dreq_i,
  input  logic             gnt_i,
  output logic             req_o,
  output logic             fire_o,
  output logic             finish_o
);

  seq_state_e st_q, st_d;
  logic       cnt_zero, cnt_last;

  assign cnt_zero = (cnt_i == '0);
  assign cnt_last = (cnt_i == CNT_W'(1));

  assign fire_o   = (st_q == ST_OWN) && start_i && gnt_i && dreq_i && !cnt_zero;
  assign finish_o = (fire_o && cnt_last) ||
                    ((st_q == ST_IDLE) && start_i && cnt_zero);
  assign req_o    = (st_q == ST_OWN);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i && dreq_i && !cnt_zero) st_d = ST_OWN;
      end
      ST_OWN: begin
        if (!start_i || cnt_zero)       st_d = ST_IDLE;
        else if (fire_o && cnt_last)    st_d = ST_IDLE;
        else if (fire_o && !burst_i)    st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  AST_STEAL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && !burst_i |=> !req_o); // R7
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && burst_i && !cnt_last |=> req_o); // R6
  AST_LAST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o && cnt_last |=> !req_o); // R8
  AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !req_o && cnt_zero |=> !req_o); // R9

endmodule

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl
  import dma_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cs_i,
  input  logic [1:0]        cfg_rs_i,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              dev_req_i,
  output logic              dev_ack_o,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic              bus_drive_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic              irq_o
);

  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              dir, burst, start;
  logic              req, fire, finish, owned;

  dma_regs #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_i     (cfg_cs_i),
    .sel_i    (cfg_rs_i),
    .we_i     (cfg_we_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .step_i   (fire),
    .finish_i (finish),
    .addr_o   (addr),
    .cnt_o    (cnt),
    .dir_o    (dir),
    .burst_o  (burst),
    .start_o  (start),
    .irq_o    (irq_o)
  );

  dma_seq #(
    .CNT_W (CNT_W)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .burst_i  (burst),
    .cnt_i    (cnt),
    .dreq_i   (dev_req_i),
    .gnt_i    (bus_gnt_i),
    .req_o    (req),
    .fire_o   (fire),
    .finish_o (finish)
  );

  assign owned       = req && bus_gnt_i;
  assign bus_req_o   = req;
  assign bus_drive_o = owned;
  assign mem_addr_o  = owned ? addr : '0;
  assign mem_wr_o    = fire && !dir;
  assign mem_rd_o    = fire && dir;
  assign dev_ack_o   = fire;

  AST_STROBE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_o || mem_wr_o) |-> bus_drive_o && bus_gnt_i); // R3
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd_o, mem_wr_o}) <= 1); // R4

endmodule

// File: tb/dma_xfer_ctrl_tb.sv
module dma_xfer_ctrl_tb;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DATA_W = 16;

  logic              clk;
  logic              rst_n;
  logic              cfg_cs, cfg_we;
  logic [1:0]        cfg_rs;
  logic [DATA_W-1:0] cfg_wdata, cfg_rdata;
  logic              dev_req, dev_ack, bus_req, bus_gnt, bus_drive;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_rd, mem_wr, irq;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              rd;
  } word_t;

  word_t exp_q[$];
  int    checks;
  int    errors;
  int    br_rises;
  logic  br_prev;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  dma_xfer_ctrl #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .DATA_W (DATA_W)
  ) u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_cs_i    (cfg_cs),
    .cfg_rs_i    (cfg_rs),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_rdata_o (cfg_rdata),
    .dev_req_i   (dev_req),
    .dev_ack_o   (dev_ack),
    .bus_req_o   (bus_req),
    .bus_gnt_i   (bus_gnt),
    .bus_drive_o (bus_drive),
    .mem_addr_o  (mem_addr),
    .mem_rd_o    (mem_rd),
    .mem_wr_o    (mem_wr),
    .irq_o       (irq)
  );

  // processor model: grants the bus one cycle after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req;
  end

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every word cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req && !br_prev) br_rises++;
      br_prev = bus_req;
      if (bus_req && !bus_gnt)
        check(!bus_drive && mem_addr == '0, "R11 no drive before grant",
              {15'd0, bus_drive, mem_addr}, 32'd0);
      if (!bus_drive && (mem_addr != '0 || mem_rd || mem_wr))
        check(1'b0, "R11 outputs active while not owned", mem_addr, 32'd0);
      if (mem_rd || mem_wr) begin
        word_t e;
        check(bus_gnt && bus_req, "R3 strobe without grant", {bus_gnt, bus_req}, 32'd3);
        check(dev_ack, "R4 device acknowledge", dev_ack, 32'd1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected word", mem_addr, 32'd0);
        end else begin
          e = exp_q.pop_front();
          check(mem_addr == e.addr, "R4 address", mem_addr, e.addr);
          check(mem_rd == e.rd, "R4 direction", mem_rd, e.rd);
        end
      end else if (dev_ack) begin
        check(1'b0, "R4 acknowledge without strobe", dev_ack, 32'd0);
      end
    end else begin
      br_prev = 1'b0;
    end
  end

  task automatic cpu_wr(input logic [1:0] rs, input logic [DATA_W-1:0] d);
    cfg_cs = 1'b1; cfg_rs = rs; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; cfg_cs = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] rs, output logic [DATA_W-1:0] d);
    cfg_cs = 1'b1; cfg_rs = rs;
    #1;
    d = cfg_rdata;
    cfg_cs = 1'b0;
  endtask

  task automatic push_words(input logic [ADDR_W-1:0] base, input int n, input logic rd);
    for (int i = 0; i < n; i++) begin
      word_t w;
      w.addr = base + ADDR_W'(i);
      w.rd   = rd;
      exp_q.push_back(w);
    end
  endtask

  task automatic wait_irq();
    while (!irq) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    logic [DATA_W-1:0] rd;
    checks = 0; errors = 0; br_rises = 0; br_prev = 1'b0;
    rst_n = 1'b0; cfg_cs = 1'b0; cfg_we = 1'b0; cfg_rs = 2'b00;
    cfg_wdata = '0; dev_req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 reset state
    check(!bus_req && !irq && !bus_drive && !dev_ack, "R2 outputs after reset",
          {bus_req, irq, bus_drive, dev_ack}, 32'd0);
    check(mem_addr == '0 && !mem_rd && !mem_wr, "R11 idle bus outputs", mem_addr, 32'd0);
    cpu_rd(2'b00, rd); check(rd == '0, "R2 address reset", rd, 32'd0);
    cpu_rd(2'b10, rd); check(rd == '0, "R2 control reset", rd, 32'd0);

    // R1 register map and readback
    cpu_wr(2'b00, 16'h1234);
    cpu_wr(2'b01, 16'h0005);
    cpu_wr(2'b10, 16'h0002);
    cpu_rd(2'b00, rd); check(rd == 16'h1234, "R1 address readback", rd, 32'h1234);
    cpu_rd(2'b01, rd); check(rd == 16'h0005, "R1 count readback", rd, 32'h5);
    cpu_rd(2'b10, rd); check(rd == 16'h0002, "R1 control readback", rd, 32'h2);
    cpu_rd(2'b11, rd); check(rd == '0, "R1 unused index reads zero", rd, 32'd0);
    check(cfg_rdata == '0, "R1 deselected reads zero", cfg_rdata, 32'd0);

    // burst, device to memory
    cpu_wr(2'b00, 16'h0100);
    cpu_wr(2'b01, 16'd4);
    push_words(16'h0100, 4, 1'b0);
    br_rises = 0;
    dev_req = 1'b1;
    cpu_wr(2'b10, 16'h0006);
    @(negedge clk);
    check(bus_req, "R3 request after start", bus_req, 32'd1);
    wait_irq();
    dev_req = 1'b0;
    check(exp_q.size() == 0, "R4 burst words all seen", exp_q.size(), 32'd0);
    check(br_rises == 1, "R6 single request in burst", br_rises, 32'd1);
    cpu_rd(2'b00, rd); check(rd == 16'h0104, "R5 address stepped", rd, 32'h104);
    cpu_rd(2'b01, rd); check(rd == '0, "R5 count stepped to zero", rd, 32'd0);
    cpu_rd(2'b10, rd); check(rd == 16'h0002, "R8 start cleared", rd, 32'h2);
    check(!bus_req, "R8 request dropped", bus_req, 32'd0);
    repeat (3) @(negedge clk);
    check(irq, "R8 interrupt held", irq, 32'd1);
    cpu_wr(2'b10, 16'h0000);
    check(!irq, "R8 interrupt cleared by control write", irq, 32'd0);

    // cycle stealing, memory to device
    cpu_wr(2'b00, 16'h2000);
    cpu_wr(2'b01, 16'd3);
    push_words(16'h2000, 3, 1'b1);
    br_rises = 0;
    dev_req = 1'b1;
    cpu_wr(2'b10, 16'h0005);
    wait_irq();
    dev_req = 1'b0;
    check(exp_q.size() == 0, "R4 steal words all seen", exp_q.size(), 32'd0);
    check(br_rises == 3, "R7 request per word", br_rises, 32'd3);
    cpu_rd(2'b00, rd); check(rd == 16'h2003, "R5 address after steal", rd, 32'h2003);
    cpu_wr(2'b10, 16'h0000);

    // burst with a gap in the device request
    cpu_wr(2'b00, 16'h0040);
    cpu_wr(2'b01, 16'd3);
    push_words(16'h0040, 3, 1'b0);
    br_rises = 0;
    dev_req = 1'b1;
    cpu_wr(2'b10, 16'h0006);
    while (!mem_wr) @(negedge clk);
    @(posedge clk);
    #1 dev_req = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(bus_req && !mem_wr, "R6 held with no strobe in gap", {bus_req, mem_wr}, 32'd2);
    end
    dev_req = 1'b1;
    wait_irq();
    dev_req = 1'b0;
    check(exp_q.size() == 0, "R6 gap words all seen", exp_q.size(), 32'd0);
    check(br_rises == 1, "R6 single request across gap", br_rises, 32'd1);
    cpu_wr(2'b10, 16'h0000);

    // zero count start
    cpu_wr(2'b01, 16'd0);
    br_rises = 0;
    dev_req = 1'b1;
    cpu_wr(2'b10, 16'h0006);
    @(negedge clk);
    check(irq, "R9 interrupt on zero count", irq, 32'd1);
    check(br_rises == 0 && !bus_req, "R9 no request on zero count", br_rises, 32'd0);
    cpu_rd(2'b10, rd); check(rd == 16'h0002, "R9 start cleared", rd, 32'h2);
    dev_req = 1'b0;
    cpu_wr(2'b10, 16'h0000);

    // count write in the same cycle as a word
    cpu_wr(2'b00, 16'h0300);
    cpu_wr(2'b01, 16'd10);
    push_words(16'h0300, 3, 1'b0);
    dev_req = 1'b1;
    cpu_wr(2'b10, 16'h0006);
    while (!mem_wr) @(negedge clk);
    cpu_wr(2'b01, 16'd2);
    cpu_rd(2'b01, rd); check(rd == 16'd2, "R10 count write wins", rd, 32'd2);
    wait_irq();
    dev_req = 1'b0;
    check(exp_q.size() == 0, "R10 words after overwrite", exp_q.size(), 32'd0);
    cpu_rd(2'b00, rd); check(rd == 16'h0303, "R10 address still stepped", rd, 32'h303);
    cpu_wr(2'b10, 16'h0000);
    check(!irq, "R8 interrupt cleared at end", irq, 32'd0);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule